// File: doc/BRIEF.md
# Analog Pipeline Cell Address Controller

This block steers a ring of analog storage cells (96 per channel by default) that capture a shaped detector pulse once per sample clock. Each cycle it names the cell to write next, stepping upward around the ring. When a level-1 accept arrives, the controller works out which cells already hold the triggered pulse. It finds them by stepping back from the current write cell by a programmed latency, measured in samples. It then protects those eight consecutive cells from being overwritten.

Protected groups wait in arrival order for a readout sequencer. The sequencer presents the eight cell addresses of a group to the digitizer on eight consecutive cycles, oldest sample first, and then returns the cells to the free pool. Writing never pauses. Instead, the write pointer jumps over every protected cell. An accept is refused, with a one-cycle flag, in any of three cases: the latency setting is unusable, the target cells overlap a group still held, or too few cells would stay free to cover the latency window.

Top module: `sca_cell_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `wr_addr` is 0, `rd_valid` is 0 and `ovf` is 0.
- R2: On every clock edge out of reset, `wr_addr` moves to the next cell in ascending circular order (95 is followed by 0) when that cell is not held.
- R3: A held cell is never written: the pointer moves to the first cell after the current one, in circular order, that is not held at that edge.
- R4: An accepted trigger sampled at a clock edge holds the 8 cells starting at (`wr_addr` before that edge − `lat_cfg`) mod 96.
- R5: A held group is read on 8 consecutive cycles with `rd_valid` high, and `rd_addr` runs from the start cell upward with circular wrap.
- R6: Held groups are read out strictly in the order their triggers were accepted, and each accepted trigger yields exactly one group of reads.
- R7: The cells of a group are released at the clock edge that ends its last read, so a later trigger can again hold them or the write pointer can reuse them.
- R8: A trigger is refused when the free cell count before the edge is below 8 + `lat_cfg`.
- R9: A trigger is refused when any of its 8 target cells is still held.
- R10: A trigger is refused when `lat_cfg` is outside 8..88.
- R11: A refused trigger raises `ovf` for exactly the one cycle after the edge that sampled it, and it holds no cells and produces no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one cell written per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1a | input | 1 | Level-1 accept, sampled on the rising edge |
| lat_cfg | input | 7 | Trigger latency in samples |
| wr_addr | output | 7 | Cell being written this cycle |
| rd_addr | output | 7 | Cell presented to the digitizer |
| rd_valid | output | 1 | `rd_addr` is valid this cycle |
| ovf | output | 1 | One-cycle pulse after a refused trigger |

## Verification
The delicate overlap is a trigger sampled on the same edge that releases a finished group. The controller must judge that trigger against the lock state from before the release. A second overlap is the write pointer reaching a freshly held group while its readout is still running. The bench provokes both by spacing triggers exactly as far apart as one readout takes, with latency settings of 64 and 88. At 88 the held group sits just ahead of the write pointer. A bench-side model of the held cells predicts every acceptance, every pointer jump and every read address, and the readout order is compared through a scoreboard queue.

// File: rtl/sca_cell_pkg.sv
`timescale 1ns/1ps
package sca_cell_pkg;

   // a + b reduced into 0..n-1, valid for a < n and b <= n
   function automatic int ring_add(int a, int b, int n);
      int s;
      s = a + b;
      if (s >= n) s = s - n;
      return s;
   endfunction

   // distance walked upward from s to reach c on a ring of n
   function automatic int ring_dist(int c, int s, int n);
      return ring_add(c, n - s, n);
   endfunction

endpackage

// File: rtl/sca_wr_ptr.sv
`timescale 1ns/1ps
module sca_wr_ptr
   import sca_cell_pkg::*;
#(
   parameter int NCELL = 96,
   localparam int AW = $clog2(NCELL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCELL-1:0] held_i,
   output logic [AW-1:0]    wr_addr_o
);

   logic [AW-1:0] ptr_q, ptr_d;

   // scan forward from the cell after ptr_q for the first free cell
   always_comb begin
      logic found;
      int   idx;
      found = 1'b0;
      ptr_d = ptr_q;
      for (int k = 1; k <= NCELL; k++) begin
         idx = ring_add(int'(ptr_q), k, NCELL);
         if (!found && !held_i[AW'(idx)]) begin
            ptr_d = AW'(idx);
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign wr_addr_o = ptr_q;

   // R2
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < NCELL);

endmodule

// File: rtl/sca_blk_fifo.sv
`timescale 1ns/1ps
module sca_blk_fifo #(
   parameter int DEPTH = 12,
   parameter int W = 7,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o,
   output logic         full_o
);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push_i) mem[wp_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wp_q <= bump(wp_q);
         if (pop_i)  rp_q <= bump(rp_q);
         if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
         else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
      end
   end

   assign dout_o  = mem[rp_q];
   assign empty_o = (cnt_q == '0);
   assign full_o  = (int'(cnt_q) == DEPTH);

   // R6
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);

   // R6
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/sca_rd_seq.sv
`timescale 1ns/1ps
module sca_rd_seq
   import sca_cell_pkg::*;
#(
   parameter int NCELL = 96,
   parameter int BLK = 8,
   localparam int AW = $clog2(NCELL),
   localparam int CW = $clog2(BLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_empty_i,
   input  logic [AW-1:0] q_head_i,
   output logic          q_pop_o,
   output logic          rd_valid_o,
   output logic [AW-1:0] rd_addr_o,
   output logic          rel_o,
   output logic [AW-1:0] rel_base_o
);

   logic          busy_q;
   logic [CW-1:0] step_q;
   logic [AW-1:0] base_q;
   logic          last;

   assign last    = busy_q && (int'(step_q) == BLK - 1);
   assign q_pop_o = !q_empty_i && (!busy_q || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         base_q <= '0;
      end else if (q_pop_o) begin
         busy_q <= 1'b1;
         step_q <= '0;
         base_q <= q_head_i;
      end else if (last) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         step_q <= step_q + CW'(1);
      end
   end

   assign rd_valid_o = busy_q;
   assign rd_addr_o  = AW'(ring_add(int'(base_q), int'(step_q), NCELL));
   assign rel_o      = last;
   assign rel_base_o = base_q;

   // R5
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && step_q != '0) |->
         (int'(rd_addr_o) == ring_add(int'($past(rd_addr_o)), 1, NCELL)));

endmodule

// File: rtl/sca_cell_ctrl.sv
`timescale 1ns/1ps
module sca_cell_ctrl
   import sca_cell_pkg::*;
#(
   parameter int NCELL = 96,
   parameter int BLK = 8,
   localparam int AW = $clog2(NCELL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l1a,
   input  logic [AW-1:0] lat_cfg,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          rd_valid,
   output logic          ovf
);

   localparam int QD = NCELL / BLK;
   localparam int NW = $clog2(NCELL + 1);

   if (BLK < 2 || BLK > NCELL / 2) begin : g_bad_blk
      $error("BLK must lie in 2..NCELL/2");
   end
   if (NCELL % BLK != 0) begin : g_bad_ring
      $error("NCELL must be a multiple of BLK");
   end

   logic [NCELL-1:0] held_q, held_d, grab_m, drop_m;
   logic [AW-1:0]    start, head, rel_base;
   logic [NW-1:0]    held_cnt;
   logic             lat_ok, clash, room, accept, ovf_q;
   logic             rel, pop, q_empty, q_full;

   assign lat_ok = (int'(lat_cfg) >= BLK) && (int'(lat_cfg) <= NCELL - BLK);
   assign start  = lat_ok ?
                   AW'(ring_add(int'(wr_addr), NCELL - int'(lat_cfg), NCELL)) : '0;

   // per-cell membership in the group being grabbed and the group released
   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      assign grab_m[c] = ring_dist(c, int'(start), NCELL) < BLK;
      assign drop_m[c] = rel && (ring_dist(c, int'(rel_base), NCELL) < BLK);
   end

   always_comb begin
      held_cnt = '0;
      for (int i = 0; i < NCELL; i++) held_cnt = held_cnt + NW'(held_q[i]);
   end

   assign room   = (NCELL - int'(held_cnt)) >= (BLK + int'(lat_cfg));
   assign clash  = |(held_q & grab_m);
   assign accept = l1a && lat_ok && !clash && room;
   assign held_d = (held_q & ~drop_m) | (accept ? grab_m : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         held_q <= held_d;
         ovf_q  <= l1a && !accept;
      end
   end

   sca_wr_ptr #(.NCELL(NCELL)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .held_i   (held_q),
      .wr_addr_o(wr_addr)
   );

   sca_blk_fifo #(.DEPTH(QD), .W(AW)) u_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (accept),
      .din_i  (start),
      .pop_i  (pop),
      .dout_o (head),
      .empty_o(q_empty),
      .full_o (q_full)
   );

   sca_rd_seq #(.NCELL(NCELL), .BLK(BLK)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_empty_i (q_empty),
      .q_head_i  (head),
      .q_pop_o   (pop),
      .rd_valid_o(rd_valid),
      .rd_addr_o (rd_addr),
      .rel_o     (rel),
      .rel_base_o(rel_base)
   );

   assign ovf = ovf_q;

   // R3
   wr_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !held_q[wr_addr]);

   // R5
   rd_is_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> held_q[rd_addr]);

   // R4
   grab_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rel) |=> (held_cnt == $past(held_cnt) + NW'(BLK)));

   // R11
   no_hold_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l1a && !accept && !rel) |=> (held_cnt == $past(held_cnt)));

endmodule

// File: tb/tb_sca_cell_ctrl.sv
`timescale 1ns/1ps
module tb_sca_cell_ctrl;
   localparam int N  = 96;
   localparam int B  = 8;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l1a = 1'b0;
   logic [AW-1:0] lat = AW'(64);
   logic [AW-1:0] wr_addr, rd_addr;
   logic          rd_valid, ovf;

   sca_cell_ctrl dut (
      .clk(clk), .rst_n(rst_n), .l1a(l1a), .lat_cfg(lat),
      .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_valid(rd_valid), .ovf(ovf)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit mdl  [N];
   bit snap [N];
   int exp_q [$];
   int blk_q [$];
   int rd_in_blk = 0;
   int pend = -1;
   int prev_wr = 0;
   bit track = 1'b0;
   bit done = 1'b0;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_free(int from);
      for (int k = 1; k <= N; k++) begin
         if (!snap[(from + k) % N]) return (from + k) % N;
      end
      return from;
   endfunction

   // monitor: pointer model and readout scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         track = 1'b0;
         pend = -1;
         rd_in_blk = 0;
      end else begin
         if (pend >= 0) begin
            for (int i = 0; i < B; i++) mdl[(pend + i) % N] = 1'b0;
            pend = -1;
         end
         if (track) begin
            int e;
            e = next_free(prev_wr);
            chk(int'(wr_addr) == e, (e == (prev_wr + 1) % N) ? "R2" : "R3",
                int'(wr_addr), e);
         end
         if (rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R11 stray read", int'(rd_addr), -1);
            else begin
               int e;
               e = exp_q.pop_front();
               chk(int'(rd_addr) == e, "R4/R5/R6 read", int'(rd_addr), e);
            end
            rd_in_blk++;
            if (rd_in_blk == B) begin
               rd_in_blk = 0;
               if (blk_q.size() != 0) pend = blk_q.pop_front();
            end
         end
         prev_wr = int'(wr_addr);
         snap = mdl;
         track = 1'b1;
      end
   end

   // driver: fires one trigger and predicts whether it is taken
   task automatic fire(string req);
      int w, lv, st, cnt;
      bit ok;
      @(negedge clk); #1;
      w  = int'(wr_addr);
      lv = int'(lat);
      ok = (lv >= B) && (lv <= N - B);
      st = ok ? (w - lv + N) % N : 0;
      cnt = 0;
      for (int i = 0; i < N; i++) cnt += int'(mdl[i]);
      if (ok) begin
         for (int i = 0; i < B; i++) if (mdl[(st + i) % N]) ok = 1'b0;
         if (N - cnt < B + lv) ok = 1'b0;
      end
      if (ok) begin
         for (int i = 0; i < B; i++) begin
            mdl[(st + i) % N] = 1'b1;
            exp_q.push_back((st + i) % N);
         end
         blk_q.push_back(st);
      end
      l1a = 1'b1;
      @(negedge clk); #1;
      l1a = 1'b0;
      chk(ovf == !ok, req, int'(ovf), int'(!ok));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(wr_addr == '0, "R1 wr_addr", int'(wr_addr), 0);
      chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
      chk(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
      #1 rst_n = 1'b1;
      idle(20);
      // single group, latency 64
      fire("R4");
      idle(20);
      // back to back groups, order kept
      fire("R4");
      idle(7);
      fire("R6");
      idle(30);
      // overlapping target cells
      fire("R4");
      idle(1);
      fire("R9");
      idle(30);
      // group that wraps 95 -> 0
      do @(negedge clk); while (int'(wr_addr) != 59);
      fire("R5 wrap");
      idle(30);
      // latency 88: group sits ahead of the pointer, pointer must jump it
      lat = AW'(88);
      idle(2);
      fire("R4");
      idle(7);
      fire("R8");
      idle(2);
      fire("R7");
      idle(30);
      // unusable latency settings
      lat = AW'(5);
      fire("R10 low");
      lat = AW'(90);
      fire("R10 high");
      lat = AW'(64);
      idle(5);
      // trigger on the release edge of the previous group
      fire("R4");
      idle(7);
      fire("R7 same edge");
      idle(30);
      // burst at latency 48
      lat = AW'(48);
      for (int j = 0; j < 4; j++) begin
         fire("R6 burst");
         idle(6);
      end
      idle(120);
      chk(exp_q.size() == 0, "R6 drained", exp_q.size(), 0);
      chk(ovf == 1'b0, "R11 idle ovf", int'(ovf), 0);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule